// File: doc/BRIEF.md
# Coprocessor Control and Status Word

This block holds the control and status flags of a slave coprocessor as the host processor sees them. The host changes flags by writing one 32-bit word in which each flag owns a clear bit and, for most flags, a set bit. Writing 1 to a set bit raises its flag and writing 1 to a clear bit lowers it. Bits written as 0 leave their flag alone, so the host can change one flag without first reading the others.

The flags are halt, broke, interrupt, single-step, interrupt-on-break and a bank of general signal bits. Software uses signal 0 to ask for a yield, signal 1 to report that the coprocessor has yielded, and signal 2 to report that a task is done. A read returns the stored flags packed at positions that differ from the write positions, together with three live status inputs from the DMA engine. The block drives the coprocessor halt and single-step controls and the host interrupt line. A break pulse from the coprocessor stops it and marks it broken, and it interrupts the host when interrupt-on-break is enabled.

Top module: `cop_status_ctl`

## Requirements
- R1: Out of reset halt is 1 and every other flag is 0, so the read word is 32'h0000_0001, halt_o is 1, and sstep_o and host_irq_o are 0.
- R2: A write with bit 1 set and bit 0 clear sets halt. A write with bit 0 set and bit 1 clear clears halt. halt_o and read bit 0 show the flag from the cycle after the write edge.
- R3: Write bit 2 clears broke, and no write pattern sets broke. Broke is shown on read bit 1.
- R4: Write bit 4 sets the interrupt flag and write bit 3 clears it. host_irq_o equals the interrupt flag, and the flag does not appear in the read word.
- R5: Write bit 6 sets single-step and write bit 5 clears it. The flag drives sstep_o and read bit 5.
- R6: Write bit 8 sets interrupt-on-break and write bit 7 clears it. The flag is shown on read bit 6.
- R7: Signal n, for n from 0 to 7, is cleared by write bit 9+2n, set by write bit 10+2n, and read on bit 7+n.
- R8: When the set bit and the clear bit of one flag are both 1 in the same write, that flag keeps its value.
- R9: A one-cycle break pulse sets broke and halt. If interrupt-on-break is 1 before that edge, the pulse also sets the interrupt flag. If it is 0, the interrupt flag is unchanged.
- R10: A break pulse takes priority over a write in the same cycle that clears halt, broke or the interrupt. Those flags end up set.
- R11: Read bits 2, 3 and 4 show the live DMA busy, DMA full and IO full inputs without delay. Read bits 15 to 31 are 0, and write bits 25 to 31 have no effect.
- R12: With wr_en low, no flag changes, whatever wr_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 32 | Write word made of paired set and clear bits |
| rd_data | output | 32 | Packed read word |
| dma_busy_i | input | 1 | Live DMA busy status |
| dma_full_i | input | 1 | Live DMA full status |
| io_full_i | input | 1 | Live IO full status |
| brk_pulse_i | input | 1 | One-cycle break event from the coprocessor |
| halt_o | output | 1 | Holds the coprocessor in halt |
| sstep_o | output | 1 | Single-step enable to the coprocessor |
| host_irq_o | output | 1 | Interrupt request to the host |

## Verification
Directed writes toggle each flag on its own. These show whether every set bit and every clear bit reaches the right flag and the right read position. Writes with both bits of a pair set, writes with only the reserved high bits set, and strobes with wr_en low show the difference between a hold and an unintended change. Break pulses are issued with interrupt-on-break both off and on, and together with clearing writes, which checks the conditional interrupt and the priority of the break. A long run of random write words, random break pulses and random live status inputs is then compared every cycle against a flag model kept in the bench, to catch mismatches that only appear when writes and breaks combine.

// File: rtl/cop_status_pkg.sv
package cop_status_pkg;

    // Write-word bit positions (host-visible encoding)
    localparam int WB_HALT_CLR  = 0;
    localparam int WB_HALT_SET  = 1;
    localparam int WB_BROKE_CLR = 2;
    localparam int WB_IRQ_CLR   = 3;
    localparam int WB_IRQ_SET   = 4;
    localparam int WB_SSTEP_CLR = 5;
    localparam int WB_SSTEP_SET = 6;
    localparam int WB_IBRK_CLR  = 7;
    localparam int WB_IBRK_SET  = 8;
    localparam int WB_SIG_BASE  = 9;   // signal n: clear at base+2n, set at base+2n+1

    // Read-word bit positions
    localparam int RB_HALT      = 0;
    localparam int RB_BROKE     = 1;
    localparam int RB_DMA_BUSY  = 2;
    localparam int RB_DMA_FULL  = 3;
    localparam int RB_IO_FULL   = 4;
    localparam int RB_SSTEP     = 5;
    localparam int RB_IBRK      = 6;
    localparam int RB_SIG_BASE  = 7;

    // Flat flag-vector index order used between decoder and register bank
    localparam int FI_HALT      = 0;
    localparam int FI_BROKE     = 1;
    localparam int FI_IRQ       = 2;
    localparam int FI_SSTEP     = 3;
    localparam int FI_IBRK      = 4;
    localparam int FI_SIG_BASE  = 5;
    localparam int NUM_CTRL     = 5;

    // Packed so that bit k matches flat index k
    typedef struct packed {
        logic ibrk;
        logic sstep;
        logic irq;
        logic broke;
        logic halt;
    } ctrl_t;

endpackage

// File: rtl/cop_wr_decode.sv
module cop_wr_decode
    import cop_status_pkg::*;
#(
    parameter  int DATA_W  = 32,
    parameter  int NUM_SIG = 8,
    localparam int NFLAG   = NUM_CTRL + NUM_SIG,
    localparam int WR_USED = WB_SIG_BASE + 2 * NUM_SIG
) (
    input  logic [DATA_W-1:0] wr_data,
    output logic [NFLAG-1:0]  set_v,
    output logic [NFLAG-1:0]  clr_v
);

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:WR_USED];

    assign set_v[FI_HALT]  = wr_data[WB_HALT_SET];
    assign clr_v[FI_HALT]  = wr_data[WB_HALT_CLR];
    assign set_v[FI_BROKE] = 1'b0;                 // broke has no set bit
    assign clr_v[FI_BROKE] = wr_data[WB_BROKE_CLR];
    assign set_v[FI_IRQ]   = wr_data[WB_IRQ_SET];
    assign clr_v[FI_IRQ]   = wr_data[WB_IRQ_CLR];
    assign set_v[FI_SSTEP] = wr_data[WB_SSTEP_SET];
    assign clr_v[FI_SSTEP] = wr_data[WB_SSTEP_CLR];
    assign set_v[FI_IBRK]  = wr_data[WB_IBRK_SET];
    assign clr_v[FI_IBRK]  = wr_data[WB_IBRK_CLR];

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
        assign clr_v[FI_SIG_BASE+g] = wr_data[WB_SIG_BASE+2*g];
        assign set_v[FI_SIG_BASE+g] = wr_data[WB_SIG_BASE+2*g+1];
    end

endmodule

// File: rtl/cop_flag_regs.sv
module cop_flag_regs
    import cop_status_pkg::*;
#(
    parameter  int NUM_SIG = 8,
    localparam int NFLAG   = NUM_CTRL + NUM_SIG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NFLAG-1:0]   set_v,
    input  logic [NFLAG-1:0]   clr_v,
    input  logic               brk_pulse,
    output ctrl_t              ctrl_q,
    output logic [NUM_SIG-1:0] sig_q
);

    typedef struct packed {
        ctrl_t              ctrl;
        logic [NUM_SIG-1:0] sig;
    } state_t;

    // halt sits at bit NUM_SIG of the packed state
    localparam logic [NFLAG-1:0] RST_BITS = {{(NUM_CTRL-1){1'b0}}, 1'b1, {NUM_SIG{1'b0}}};

    state_t           st_d, st_q;
    logic [NFLAG-1:0] flat_q;
    logic [NFLAG-1:0] flat_wr;

    assign flat_q = {st_q.sig, st_q.ctrl};

    // Per-flag write rule: exactly one of set/clear acts, both or none hold
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        assign flat_wr[i] = (wr_en && (set_v[i] ^ clr_v[i])) ? set_v[i] : flat_q[i];
    end

    always_comb begin
        st_d.ctrl = ctrl_t'(flat_wr[NUM_CTRL-1:0]);
        st_d.sig  = flat_wr[NFLAG-1:NUM_CTRL];
        if (brk_pulse) begin
            st_d.ctrl.halt  = 1'b1;
            st_d.ctrl.broke = 1'b1;
            if (st_q.ctrl.ibrk) begin
                st_d.ctrl.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= state_t'(RST_BITS);
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;
    assign sig_q  = st_q.sig;

endmodule

// File: rtl/cop_rd_pack.sv
module cop_rd_pack
    import cop_status_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_SIG = 8
) (
    input  logic               halt,
    input  logic               broke,
    input  logic               sstep,
    input  logic               ibrk,
    input  logic [NUM_SIG-1:0] sig,
    input  logic               dma_busy,
    input  logic               dma_full,
    input  logic               io_full,
    output logic [DATA_W-1:0]  rd_word
);

    always_comb begin
        rd_word              = '0;
        rd_word[RB_HALT]     = halt;
        rd_word[RB_BROKE]    = broke;
        rd_word[RB_DMA_BUSY] = dma_busy;
        rd_word[RB_DMA_FULL] = dma_full;
        rd_word[RB_IO_FULL]  = io_full;
        rd_word[RB_SSTEP]    = sstep;
        rd_word[RB_IBRK]     = ibrk;
        for (int i = 0; i < NUM_SIG; i++) begin
            rd_word[RB_SIG_BASE+i] = sig[i];
        end
    end

endmodule

// File: rtl/cop_status_ctl.sv
module cop_status_ctl
    import cop_status_pkg::*;
#(
    parameter  int DATA_W  = 32,
    parameter  int NUM_SIG = 8,
    localparam int NFLAG   = NUM_CTRL + NUM_SIG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dma_busy_i,
    input  logic              dma_full_i,
    input  logic              io_full_i,
    input  logic              brk_pulse_i,
    output logic              halt_o,
    output logic              sstep_o,
    output logic              host_irq_o
);

    logic [NFLAG-1:0]   set_v;
    logic [NFLAG-1:0]   clr_v;
    ctrl_t              ctrl_q;
    logic [NUM_SIG-1:0] sig_q;

    cop_wr_decode #(
        .DATA_W (DATA_W),
        .NUM_SIG(NUM_SIG)
    ) u_dec (
        .wr_data(wr_data),
        .set_v  (set_v),
        .clr_v  (clr_v)
    );

    cop_flag_regs #(
        .NUM_SIG(NUM_SIG)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .set_v    (set_v),
        .clr_v    (clr_v),
        .brk_pulse(brk_pulse_i),
        .ctrl_q   (ctrl_q),
        .sig_q    (sig_q)
    );

    cop_rd_pack #(
        .DATA_W (DATA_W),
        .NUM_SIG(NUM_SIG)
    ) u_pack (
        .halt    (ctrl_q.halt),
        .broke   (ctrl_q.broke),
        .sstep   (ctrl_q.sstep),
        .ibrk    (ctrl_q.ibrk),
        .sig     (sig_q),
        .dma_busy(dma_busy_i),
        .dma_full(dma_full_i),
        .io_full (io_full_i),
        .rd_word (rd_data)
    );

    assign halt_o     = ctrl_q.halt;
    assign sstep_o    = ctrl_q.sstep;
    assign host_irq_o = ctrl_q.irq;

endmodule

// File: rtl/cop_status_ctl_chk.sv
module cop_status_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        dma_busy_i,
    input logic        dma_full_i,
    input logic        io_full_i,
    input logic        brk_pulse_i,
    input logic        halt_o,
    input logic        sstep_o,
    input logic        host_irq_o
);

    AST_HALT_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1] && !wr_data[0]) |=> halt_o);  // R2

    AST_BROKE_NEVER_WRITTEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_pulse_i && !rd_data[1]) |=> !rd_data[1]);  // R3

    AST_SSTEP_READ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sstep_o == rd_data[5]);  // R5

    AST_PAIR_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[5] && wr_data[6]) |=> $stable(sstep_o));  // R8

    AST_BREAK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse_i |=> (halt_o && rd_data[1]));  // R9

    AST_BREAK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pulse_i && rd_data[6]) |=> host_irq_o);  // R9

    AST_LIVE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4:2] == {io_full_i, dma_full_i, dma_busy_i});  // R11

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:15] == 17'h0);  // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !brk_pulse_i) |=> ($stable(rd_data[1:0]) && $stable(rd_data[14:5]) && $stable(host_irq_o)));  // R12

endmodule

bind cop_status_ctl cop_status_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .dma_busy_i (dma_busy_i),
    .dma_full_i (dma_full_i),
    .io_full_i  (io_full_i),
    .brk_pulse_i(brk_pulse_i),
    .halt_o     (halt_o),
    .sstep_o    (sstep_o),
    .host_irq_o (host_irq_o)
);

// File: tb/cop_status_ctl_tb.sv
module cop_status_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        dma_busy_i = 1'b0;
    logic        dma_full_i = 1'b0;
    logic        io_full_i = 1'b0;
    logic        brk_pulse_i = 1'b0;
    logic        halt_o;
    logic        sstep_o;
    logic        host_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench flag model
    logic       m_halt, m_broke, m_irq, m_sstep, m_ibrk;
    logic [7:0] m_sig;

    always #2 clk = ~clk;

    cop_status_ctl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .dma_busy_i (dma_busy_i),
        .dma_full_i (dma_full_i),
        .io_full_i  (io_full_i),
        .brk_pulse_i(brk_pulse_i),
        .halt_o     (halt_o),
        .sstep_o    (sstep_o),
        .host_irq_o (host_irq_o)
    );

    function automatic logic [31:0] exp_rd();
        return {17'h0, m_sig, m_ibrk, m_sstep, io_full_i, dma_full_i, dma_busy_i, m_broke, m_halt};
    endfunction

    function automatic logic pair(input logic cur, input logic s, input logic c);
        if (s && !c) return 1'b1;
        if (c && !s) return 1'b0;
        return cur;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R11 read word"}, rd_data, exp_rd());
        chk({tag, " R4 host irq"}, {31'h0, host_irq_o}, {31'h0, m_irq});
        chk({tag, " R2 halt out"}, {31'h0, halt_o}, {31'h0, m_halt});
        chk({tag, " R5 sstep out"}, {31'h0, sstep_o}, {31'h0, m_sstep});
    endtask

    // Called at a falling edge; applies one cycle of stimulus and updates the model
    task automatic cyc(input logic we, input logic [31:0] wd, input logic brk);
        logic old_ibrk;
        wr_en = we;
        wr_data = wd;
        brk_pulse_i = brk;
        @(posedge clk);
        old_ibrk = m_ibrk;
        if (we) begin
            m_halt  = pair(m_halt,  wd[1], wd[0]);
            m_broke = pair(m_broke, 1'b0,  wd[2]);
            m_irq   = pair(m_irq,   wd[4], wd[3]);
            m_sstep = pair(m_sstep, wd[6], wd[5]);
            m_ibrk  = pair(m_ibrk,  wd[8], wd[7]);
            for (int n = 0; n < 8; n++) begin
                m_sig[n] = pair(m_sig[n], wd[10+2*n], wd[9+2*n]);
            end
        end
        if (brk) begin
            m_halt = 1'b1;
            m_broke = 1'b1;
            if (old_ibrk) m_irq = 1'b1;
        end
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        brk_pulse_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_halt = 1'b1; m_broke = 1'b0; m_irq = 1'b0; m_sstep = 1'b0; m_ibrk = 1'b0; m_sig = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset read word", rd_data, 32'h0000_0001);
        check_all("R1");

        // R2 halt
        cyc(1'b1, 32'h1, 1'b0);        check_all("R2 clear halt");
        chk("R2 halt low", {31'h0, halt_o}, 32'h0);
        cyc(1'b1, 32'h2, 1'b0);        check_all("R2 set halt");

        // R3 broke: every bit but bit 2 never sets it, bit 2 clears it
        cyc(1'b1, 32'hFFFF_FFFB, 1'b0); check_all("R3 no set");
        chk("R3 broke stays low", {31'h0, rd_data[1]}, 32'h0);
        cyc(1'b0, 32'h0, 1'b1);        check_all("R3 broke via break");
        cyc(1'b1, 32'h4, 1'b0);        check_all("R3 clear broke");
        chk("R3 broke cleared", {31'h0, rd_data[1]}, 32'h0);

        // R4 interrupt
        cyc(1'b1, 32'h10, 1'b0);       check_all("R4 set irq");
        chk("R4 irq high", {31'h0, host_irq_o}, 32'h1);
        cyc(1'b1, 32'h08, 1'b0);       check_all("R4 clear irq");

        // R5 single-step
        cyc(1'b1, 32'h40, 1'b0);       check_all("R5 set sstep");
        cyc(1'b1, 32'h20, 1'b0);       check_all("R5 clear sstep");

        // R6 interrupt-on-break
        cyc(1'b1, 32'h100, 1'b0);      check_all("R6 set ibrk");
        chk("R6 read bit 6", {31'h0, rd_data[6]}, 32'h1);
        cyc(1'b1, 32'h080, 1'b0);      check_all("R6 clear ibrk");

        // R7 each signal set then cleared
        for (int n = 0; n < 8; n++) begin
            cyc(1'b1, 32'h1 << (10 + 2 * n), 1'b0); check_all("R7 set signal");
            chk("R7 signal bit", rd_data[14:7], 8'h1 << n);
            cyc(1'b1, 32'h1 << (9 + 2 * n), 1'b0);  check_all("R7 clear signal");
        end

        // R8 both bits of every pair set: hold, from two starting states
        cyc(1'b1, 32'h0155_5150, 1'b0); check_all("R8 prep");
        cyc(1'b1, 32'h01FF_FFFB, 1'b0); check_all("R8 hold a");
        cyc(1'b1, 32'h00AA_AAA9, 1'b0); check_all("R8 prep b");
        cyc(1'b1, 32'h01FF_FFFB, 1'b0); check_all("R8 hold b");

        // R9 break with interrupt-on-break off then on
        cyc(1'b1, 32'h0000_0089, 1'b0); check_all("R9 prep");
        cyc(1'b0, 32'h0, 1'b1);        check_all("R9 break ibrk off");
        chk("R9 no irq", {31'h0, host_irq_o}, 32'h0);
        cyc(1'b1, 32'h0000_0105, 1'b0); check_all("R9 prep on");
        cyc(1'b0, 32'h0, 1'b1);        check_all("R9 break ibrk on");
        chk("R9 irq raised", {31'h0, host_irq_o}, 32'h1);

        // R10 break beats clearing write
        cyc(1'b1, 32'h0000_000D, 1'b1); check_all("R10 break priority");
        chk("R10 halt broke", rd_data[1:0], 32'h3);

        // R11 live inputs and reserved write bits
        dma_busy_i = 1'b1; dma_full_i = 1'b0; io_full_i = 1'b1;
        #1 check_all("R11 live a");
        dma_busy_i = 1'b0; dma_full_i = 1'b1; io_full_i = 1'b0;
        #1 check_all("R11 live b");
        cyc(1'b1, 32'hFE00_0000, 1'b0); check_all("R11 reserved write");

        // R12 strobe low
        cyc(1'b0, 32'hFFFF_FFFF, 1'b0); check_all("R12 no strobe");
        cyc(1'b0, 32'h0155_5555, 1'b0); check_all("R12 no strobe b");

        // Random phase
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4000; k++) begin
            logic        we;
            logic        brk;
            logic [31:0] wd;
            we  = ($urandom % 4) != 0;
            brk = ($urandom % 8) == 0;
            wd  = $urandom;
            if (($urandom % 4) == 0) wd = wd & 32'h0000_01FF;
            dma_busy_i = 1'($urandom);
            dma_full_i = 1'($urandom);
            io_full_i  = 1'($urandom);
            cyc(we, wd, brk);
            check_all("R8 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule